// File: doc/BRIEF.md
# Parameterised Prefix-Network Adder

This block adds two unsigned N-bit operands and returns an (N+1)-bit result with no carry input. It is organised as three stages. A row of half-adder cells forms a generate and a propagate bit for every position. A carry network of associative prefix cells then turns those pairs into the group generate `G[i:0]` for every bit. A final row of XOR gates forms the sum bits, and the last carry becomes the top bit of the result.

The carry network is chosen at elaboration time by a parameter, so the same block can be placed wherever area, depth or fan-out matters most. The serial topology uses one chain of N-1 cells and is the smallest and slowest. The Ladner-Fischer topology uses log2(N) rows of N/2 cells. Within each row, aligned groups of nodes share one lower-side input, so some nodes have high fan-out. The Kogge-Stone topology uses log2(N) rows with N-2^l cells in row l, and no node drives more than two cells. Another parameter can add a single output register with a synchronous active-high reset. The operand width must be a power of two, because the row and node counts of the parallel trees are exact only for such widths.

Top module: `pfx_add`

## Requirements
- R1: `sum` equals the arithmetic sum of `a` and `b` as unsigned numbers, for every operand pair, zero-extended to N+1 bits.
- R2: `sum[N]` is the carry out. It is 1 exactly when a+b ≥ 2^N, and it is always 1 when both operand MSBs are 1.
- R3: There is no carry input, so `sum[0]` always equals `a[0]` XOR `b[0]`.
- R4: With TOPO=0 (serial chain), the result is bit-identical to the arithmetic sum.
- R5: With TOPO=1 (Ladner-Fischer tree), the result is bit-identical to the arithmetic sum.
- R6: With TOPO=2 (Kogge-Stone tree), the result is bit-identical to the arithmetic sum.
- R7: A carry that ripples across the whole word is handled. With `a` all ones and `b`=1, `sum` is 2^N: bit N is 1 and all other bits are 0.
- R8: With REG_OUT=1, `sum` shows the result for the operands present at the previous rising clock edge. It holds that value until the next edge, even when the operands change between edges.
- R9: With REG_OUT=1, any rising edge at which `rst` is 1 clears `sum` to 0.
- R10: With REG_OUT=0, `sum` follows the operands combinationally, and `clk` and `rst` have no effect on it.
- R11: A zero operand is an identity. With `b`=0, `sum` equals `a` zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register; unused when REG_OUT=0 |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a | input | N | First unsigned operand |
| b | input | N | Second unsigned operand |
| sum | output | N+1 | Unsigned sum; bit N is the carry out |

## Verification
The bench targets the places where a prefix network goes wrong silently. These are the full-length carry chain, where a mis-wired tree node drops the carry partway up the word, and alternating bit patterns, where a wrong lower-side index in a Ladner-Fischer group or a wrong row distance in Kogge-Stone gives a wrong bit in only a few positions. It also targets the carry-out bit, which is lost if the top stage is sized N instead of N+1, and bit 0, which gets a phantom carry if a carry input is implied. All three topologies are run side by side on the same operands: exhaustively at 8 bits and with random plus corner vectors at 16 bits. The registered variant is checked for one-cycle latency, for holding its value between edges, and for being cleared by reset, while the combinational variant is shown to ignore reset.

// File: rtl/pfx_add_pkg.sv
`timescale 1ns/1ps
package pfx_add_pkg;

   // Carry-network topology codes selected by the TOPO parameter
   localparam int TOPO_SERIAL = 0;
   localparam int TOPO_LF     = 1;
   localparam int TOPO_KS     = 2;

   // True for powers of two that are at least 2
   function automatic bit is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/pfx_gp_stage.sv
`timescale 1ns/1ps
// Stage one: per-bit half adders giving generate and propagate
module pfx_gp_stage #(
   parameter int N = 16
) (
   input  logic [N-1:0] a,
   input  logic [N-1:0] b,
   output logic [N-1:0] g,
   output logic [N-1:0] p
);

   for (genvar i = 0; i < N; i++) begin : g_ha
      assign g[i] = a[i] & b[i];
      assign p[i] = a[i] ^ b[i];
   end

endmodule

// File: rtl/pfx_cell.sv
`timescale 1ns/1ps
// One prefix operator: upper pair (g_hi,p_hi) absorbs lower pair (g_lo,p_lo)
module pfx_cell #(
   parameter bit KEEP_P = 1'b1
) (
   input  logic g_hi,
   input  logic p_hi,
   input  logic g_lo,
   input  logic p_lo,
   output logic g_o,
   output logic p_o
);

   assign g_o = g_hi | (p_hi & g_lo);

   if (KEEP_P) begin : g_with_p
      assign p_o = p_hi & p_lo;
   end else begin : g_no_p
      // Group propagate not needed by this topology
      logic unused_p_lo;
      assign unused_p_lo = p_lo;
      assign p_o         = 1'b0;
   end

endmodule

// File: rtl/pfx_tree.sv
`timescale 1ns/1ps
// Stage two: carry network; carry[i] = G[i:0]
module pfx_tree #(
   parameter int N    = 16,
   parameter int TOPO = 2
) (
   input  logic [N-1:0] g,
   input  logic [N-1:0] p,
   output logic [N-1:0] carry
);
   import pfx_add_pkg::*;

   localparam int LVL = $clog2(N);

   if (TOPO == TOPO_SERIAL) begin : g_serial
      logic [N-1:0] chain;
      logic [N-1:0] p_dead;
      logic         unused_p;

      assign chain[0]  = g[0];
      assign p_dead[0] = 1'b0;
      for (genvar i = 1; i < N; i++) begin : g_link
         pfx_cell #(.KEEP_P(1'b0)) i_cell (
            .g_hi(g[i]),
            .p_hi(p[i]),
            .g_lo(chain[i-1]),
            .p_lo(1'b0),
            .g_o (chain[i]),
            .p_o (p_dead[i])
         );
      end
      assign unused_p = p[0] ^ (|p_dead);
      assign carry    = chain;

   end else begin : g_parallel
      logic [N-1:0] g_row [0:LVL];
      logic [N-1:0] p_row [0:LVL];
      logic         unused_ptop;

      assign g_row[0] = g;
      assign p_row[0] = p;

      for (genvar l = 0; l < LVL; l++) begin : g_lvl
         for (genvar i = 0; i < N; i++) begin : g_bit
            if (TOPO == TOPO_LF) begin : g_lf
               // Node combines with the top of the aligned block just below
               localparam int LO = ((i >> l) << l) - 1;
               if (((i >> l) & 1) == 1) begin : g_op
                  pfx_cell #(.KEEP_P(1'b1)) i_cell (
                     .g_hi(g_row[l][i]),
                     .p_hi(p_row[l][i]),
                     .g_lo(g_row[l][LO]),
                     .p_lo(p_row[l][LO]),
                     .g_o (g_row[l+1][i]),
                     .p_o (p_row[l+1][i])
                  );
               end else begin : g_pass
                  assign g_row[l+1][i] = g_row[l][i];
                  assign p_row[l+1][i] = p_row[l][i];
               end
            end else begin : g_ks
               // Node combines with the one 2^l positions lower
               localparam int DIST = 1 << l;
               if (i >= DIST) begin : g_op
                  pfx_cell #(.KEEP_P(1'b1)) i_cell (
                     .g_hi(g_row[l][i]),
                     .p_hi(p_row[l][i]),
                     .g_lo(g_row[l][i-DIST]),
                     .p_lo(p_row[l][i-DIST]),
                     .g_o (g_row[l+1][i]),
                     .p_o (p_row[l+1][i])
                  );
               end else begin : g_pass
                  assign g_row[l+1][i] = g_row[l][i];
                  assign p_row[l+1][i] = p_row[l][i];
               end
            end
         end
      end

      assign unused_ptop = ^p_row[LVL];
      assign carry       = g_row[LVL];
   end

endmodule

// File: rtl/pfx_sum_stage.sv
`timescale 1ns/1ps
// Stage three: sum bits from propagate and incoming carry
module pfx_sum_stage #(
   parameter int N = 16
) (
   input  logic [N-1:0] p,
   input  logic [N-1:0] carry,
   output logic [N:0]   s
);

   assign s[0] = p[0];
   for (genvar i = 1; i < N; i++) begin : g_x
      assign s[i] = p[i] ^ carry[i-1];
   end
   assign s[N] = carry[N-1];

endmodule

// File: rtl/pfx_add.sv
`timescale 1ns/1ps
module pfx_add #(
   parameter int N       = 16,
   parameter int TOPO    = 2,
   parameter int REG_OUT = 0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] a,
   input  logic [N-1:0] b,
   output logic [N:0]   sum
);
   import pfx_add_pkg::*;

   // Elaboration-time parameter checks
   if (!is_pow2(N)) begin : g_bad_n
      $error("pfx_add: N must be a power of two and at least 2");
   end
   if (TOPO < TOPO_SERIAL || TOPO > TOPO_KS) begin : g_bad_topo
      $error("pfx_add: TOPO must be 0, 1 or 2");
   end
   if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg
      $error("pfx_add: REG_OUT must be 0 or 1");
   end

   logic [N-1:0] gen_w;
   logic [N-1:0] prop_w;
   logic [N-1:0] carry_w;
   logic [N:0]   sum_d;

   pfx_gp_stage #(.N(N)) i_gp (
      .a(a),
      .b(b),
      .g(gen_w),
      .p(prop_w)
   );

   pfx_tree #(.N(N), .TOPO(TOPO)) i_tree (
      .g    (gen_w),
      .p    (prop_w),
      .carry(carry_w)
   );

   pfx_sum_stage #(.N(N)) i_sum (
      .p    (prop_w),
      .carry(carry_w),
      .s    (sum_d)
   );

   if (REG_OUT == 1) begin : g_reg
      logic [N:0] sum_q;
      always_ff @(posedge clk) begin
         if (rst) sum_q <= '0;
         else     sum_q <= sum_d;
      end
      assign sum = sum_q;
   end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst;
      assign sum            = sum_d;
   end

endmodule

// File: rtl/pfx_add_chk.sv
`timescale 1ns/1ps
module pfx_add_chk #(
   parameter int N       = 16,
   parameter int REG_OUT = 0
) (
   input logic         clk,
   input logic         rst,
   input logic [N-1:0] a,
   input logic [N-1:0] b,
   input logic [N:0]   sum
);

   logic [N:0] model_sum;
   assign model_sum = {1'b0, a} + {1'b0, b};

   if (REG_OUT == 0) begin : g_comb_chk
      // R1
      assert_sum_match_R1: assert property (@(posedge clk) disable iff (rst)
         sum == model_sum);
      // R3
      assert_lsb_no_cin_R3: assert property (@(posedge clk) disable iff (rst)
         sum[0] == (a[0] ^ b[0]));
      // R2
      assert_carry_out_R2: assert property (@(posedge clk) disable iff (rst)
         (a[N-1] & b[N-1]) |-> sum[N]);
      // R7
      assert_full_chain_R7: assert property (@(posedge clk) disable iff (rst)
         ((&a) && (b == {{(N-1){1'b0}}, 1'b1})) |-> (sum == {1'b1, {N{1'b0}}}));
      // R11
      assert_zero_ident_R11: assert property (@(posedge clk) disable iff (rst)
         (b == '0) |-> (sum == {1'b0, a}));
   end else begin : g_reg_chk
      logic armed;
      logic seen_edge;
      always_ff @(posedge clk) begin
         seen_edge <= 1'b1;
         if (rst) armed <= 1'b0;
         else     armed <= 1'b1;
      end
      // R8
      assert_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
         armed |-> (sum == $past(model_sum)));
      // R3
      assert_lsb_no_cin_R3: assert property (@(posedge clk) disable iff (rst)
         armed |-> (sum[0] == $past(a[0] ^ b[0])));
      // R2
      assert_carry_out_R2: assert property (@(posedge clk) disable iff (rst)
         (armed && $past(a[N-1] & b[N-1])) |-> sum[N]);
      // R9
      assert_reset_clear_R9: assert property (@(posedge clk)
         (seen_edge && $past(rst)) |-> (sum == '0));
   end

endmodule

bind pfx_add pfx_add_chk #(.N(N), .REG_OUT(REG_OUT)) i_chk (
   .clk(clk),
   .rst(rst),
   .a  (a),
   .b  (b),
   .sum(sum)
);

// File: tb/test_pfx_add.sv
`timescale 1ns/1ps
module test_pfx_add;

   localparam int W16 = 16;
   localparam int W8  = 8;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic [W16-1:0] a16 = '0;
   logic [W16-1:0] b16 = '0;
   logic [W8-1:0]  a8  = '0;
   logic [W8-1:0]  b8  = '0;
   logic [W16:0]   s16_ks, s16_lf, s16_ser;
   logic [W8:0]    r8_ser, r8_lf, r8_ks;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;   // 50 MHz

   // Combinational 16-bit variants
   pfx_add #(.N(W16), .TOPO(2), .REG_OUT(0)) i_pfx_add (
      .clk(clk), .rst(rst), .a(a16), .b(b16), .sum(s16_ks));
   pfx_add #(.N(W16), .TOPO(1), .REG_OUT(0)) i_pfx_add_lf16 (
      .clk(clk), .rst(rst), .a(a16), .b(b16), .sum(s16_lf));
   pfx_add #(.N(W16), .TOPO(0), .REG_OUT(0)) i_pfx_add_ser16 (
      .clk(clk), .rst(rst), .a(a16), .b(b16), .sum(s16_ser));
   // Registered 8-bit variants
   pfx_add #(.N(W8), .TOPO(0), .REG_OUT(1)) i_pfx_add_ser8 (
      .clk(clk), .rst(rst), .a(a8), .b(b8), .sum(r8_ser));
   pfx_add #(.N(W8), .TOPO(1), .REG_OUT(1)) i_pfx_add_lf8 (
      .clk(clk), .rst(rst), .a(a8), .b(b8), .sum(r8_lf));
   pfx_add #(.N(W8), .TOPO(2), .REG_OUT(1)) i_pfx_add_ks8 (
      .clk(clk), .rst(rst), .a(a8), .b(b8), .sum(r8_ks));

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic check16_all(input string req);
      logic [W16:0] e;
      e = {1'b0, a16} + {1'b0, b16};
      check({req, " R6"}, "kogge-stone 16", 32'(s16_ks), 32'(e));
      check({req, " R5"}, "ladner-fischer 16", 32'(s16_lf), 32'(e));
      check({req, " R4"}, "serial 16", 32'(s16_ser), 32'(e));
   endtask

   // R9 and R10: reset clears registers, not the combinational variants
   task automatic t_reset();
      a16 = 16'h1234; b16 = 16'h0FFF;
      a8  = 8'hFF;    b8  = 8'h01;
      repeat (3) @(negedge clk);
      check("R9", "serial8 in reset", 32'(r8_ser), 32'h0);
      check("R9", "lf8 in reset", 32'(r8_lf), 32'h0);
      check("R9", "ks8 in reset", 32'(r8_ks), 32'h0);
      check("R10", "ks16 during reset", 32'(s16_ks), 32'h2233);
      check("R10", "lf16 during reset", 32'(s16_lf), 32'h2233);
      check("R10", "ser16 during reset", 32'(s16_ser), 32'h2233);
      rst = 1'b0;
   endtask

   task automatic apply16(input logic [W16-1:0] x, input logic [W16-1:0] y);
      @(negedge clk);
      a16 = x; b16 = y;
      #2;
   endtask

   // R2, R3, R7, R11 corner patterns on the combinational variants
   task automatic t_corners16();
      apply16(16'h0000, 16'h0000); check16_all("R1 zeros");
      check("R1", "zeros ks", 32'(s16_ks), 32'h0);
      apply16(16'hFFFF, 16'h0001); check16_all("R7");
      check("R7", "full chain ks", 32'(s16_ks), 32'h10000);
      check("R7", "full chain ser", 32'(s16_ser), 32'h10000);
      check("R7", "full chain lf", 32'(s16_lf), 32'h10000);
      apply16(16'hFFFF, 16'hFFFF); check16_all("R2");
      check("R2", "carry out ones", 32'(s16_lf[W16]), 32'h1);
      apply16(16'h5555, 16'hAAAA); check16_all("R2 alt");
      check("R2", "no carry alt", 32'(s16_ks[W16]), 32'h0);
      apply16(16'hAAAA, 16'hAAAA); check16_all("R1 alt2");
      apply16(16'h5555, 16'h5555); check16_all("R1 alt3");
      apply16(16'h8000, 16'h8000); check16_all("R2 msb");
      check("R2", "msb carry ser", 32'(s16_ser), 32'h10000);
      apply16(16'h0001, 16'h0001); check16_all("R3");
      check("R3", "lsb no cin", 32'(s16_ks[0]), 32'h0);
      apply16(16'h0001, 16'h0000);
      check("R3", "lsb single", 32'(s16_lf[0]), 32'h1);
      apply16(16'hBEEF, 16'h0000); check16_all("R11");
      check("R11", "zero identity", 32'(s16_lf), 32'h0BEEF);
      apply16(16'h7FFF, 16'h0001); check16_all("R7 partial");
   endtask

   // R1, R4, R5, R6: random operand pairs across all topologies
   task automatic t_random16();
      for (int k = 0; k < 10000; k++) begin
         apply16(16'($urandom), 16'($urandom));
         check16_all("R1");
      end
   endtask

   // R8: one-cycle latency and hold between edges
   task automatic t_latency8();
      @(negedge clk);
      a8 = 8'd10; b8 = 8'd20;
      @(negedge clk);
      check("R8", "ks8 after edge", 32'(r8_ks), 32'd30);
      a8 = 8'd100; b8 = 8'd200;
      #1;
      check("R8", "ks8 holds", 32'(r8_ks), 32'd30);
      check("R8", "ser8 holds", 32'(r8_ser), 32'd30);
      @(negedge clk);
      check("R8", "lf8 next value", 32'(r8_lf), 32'd300);
   endtask

   // R1, R4, R5, R6, R8: every 8-bit operand pair through the registered variants
   task automatic t_exhaustive8();
      logic [W8:0] e;
      for (int x = 0; x < 256; x++) begin
         for (int y = 0; y < 256; y++) begin
            a8 = 8'(x); b8 = 8'(y);
            e  = 9'(x + y);
            @(negedge clk);
            check("R4 R8", "serial8", 32'(r8_ser), 32'(e));
            check("R5 R8", "lf8", 32'(r8_lf), 32'(e));
            check("R6 R8", "ks8", 32'(r8_ks), 32'(e));
         end
      end
   endtask

   // R9 and R10 again in mid-run
   task automatic t_midreset();
      a8 = 8'h80; b8 = 8'h80;
      a16 = 16'h00FF; b16 = 16'h0001;
      @(negedge clk);
      check("R8", "before reset", 32'(r8_ks), 32'h100);
      rst = 1'b1;
      @(negedge clk);
      check("R9", "ks8 cleared", 32'(r8_ks), 32'h0);
      check("R9", "lf8 cleared", 32'(r8_lf), 32'h0);
      check("R10", "ks16 ignores rst", 32'(s16_ks), 32'h100);
      rst = 1'b0;
      @(negedge clk);
      check("R9", "ks8 resumes", 32'(r8_ks), 32'h100);
   endtask

   initial begin
      t_reset();
      t_corners16();
      t_random16();
      t_latency8();
      t_exhaustive8();
      t_midreset();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired before all requirement checks ran");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule